// File: doc/BRIEF.md
# Multi-Mode Logarithmic Barrel Shifter

This block shifts or rotates a data word by any amount from zero up to one less than the word width in a single combinational pass. It does not repeat single-bit steps. It is built as a chain of log2(WIDTH) mux stages. Stage k either passes its word through or moves it right by 2^k places, depending on bit k of the shift amount. The default word is 16 bits wide, so there are four stages that move by 1, 2, 4 and 8 places.

All four operations share one right-moving stage chain:

- **Arithmetic right:** each stage fills the vacated upper bits with copies of the original sign bit.
- **Logical right:** each stage fills the vacated upper bits with zeros.
- **Rotate right:** each stage fills the vacated upper bits with the low bits that fall off the bottom.
- **Logical left:** the word is bit-reversed on entry, shifted right with zero fill, and bit-reversed again on exit.

The only thing that changes from one mode to another is the fill source of each stage. There is no clock and no state: the output follows the inputs.

Top module: `bshift_core`

## Requirements
- R1: The mode input selects the operation: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. The result for any amount from 0 to WIDTH-1 appears combinationally, with no clock edge in between.
- R2: An amount of 0 returns the data word unchanged in every mode.
- R3: In logical left mode the output equals the data shifted left by the amount, and the lowest `amount` bits are zero.
- R4: In logical right mode the output equals the data shifted right by the amount, and the highest `amount` bits are zero.
- R5: In arithmetic right mode the output equals the signed data shifted right by the amount, and the highest `amount`+1 bits all equal the data's most significant bit.
- R6: In rotate right mode, output bit i equals data bit (i+amount) mod WIDTH, and the number of ones in the word is unchanged.
- R7: Amount bit k alone moves the word by exactly 2^k places (for 16 bits: amounts 1, 2, 4 and 8), and amounts with several bits set compose these moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH (16) | Data word to shift or rotate |
| amt | input | log2(WIDTH) (4) | Shift amount, 0 to WIDTH-1 |
| mode | input | 2 | Operation select, encoded as in R1 |
| dout | output | WIDTH (16) | Shifted or rotated word |

## Verification
The embedded checks assume that the mode and amount inputs are fully driven: no X or Z bits, and an amount that always stays below WIDTH because of the port's width. They also assume the checks are evaluated once the combinational chain has settled after an input change. The stimulus meets these assumptions. It changes every input together on one clock phase and compares the output only on the opposite phase. It drives known values from time zero and sweeps all sixteen amounts in each of the four modes over word patterns that exercise sign extension, wrap-around and all-ones/all-zeros words.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    typedef enum logic [1:0] {
        SHM_LSL = 2'b00,
        SHM_LSR = 2'b01,
        SHM_ASR = 2'b10,
        SHM_ROR = 2'b11
    } shift_mode_t;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_SIGN = 2'b01,
        FILL_WRAP = 2'b10
    } fill_src_t;

    typedef struct packed {
        logic      rev;
        fill_src_t fill;
    } shift_ctl_t;

endpackage

// File: rtl/bshift_reverse.sv
module bshift_reverse #(
    parameter int WIDTH = 16
) (
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] flip_d;

    // Mirror the word bit for bit; used on entry and exit for left shifts.
    for (genvar i = 0; i < WIDTH; i++) begin : g_flip
        assign flip_d[i] = din[WIDTH-1-i];
    end

    always_comb begin
        dout = en ? flip_d : din;
    end

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage
    import bshift_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SHIFT = 1
) (
    input  logic             en,
    input  fill_src_t        fill,
    input  logic             sign,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [SHIFT-1:0] top_d;

    // Select what enters the vacated upper SHIFT positions.
    always_comb begin
        unique case (fill)
            FILL_SIGN: top_d = {SHIFT{sign}};
            FILL_WRAP: top_d = din[SHIFT-1:0];
            default:   top_d = '0;
        endcase
    end

    always_comb begin
        dout = en ? {top_d, din[WIDTH-1:SHIFT]} : din;
    end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
    import bshift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]         din,
    input  logic [$clog2(WIDTH)-1:0] amt,
    input  logic [1:0]               mode,
    output logic [WIDTH-1:0]         dout
);

    localparam int AMT_W = $clog2(WIDTH);

    shift_mode_t mode_e;
    shift_ctl_t  ctl_d;
    logic        sign_d;

    // Control decode: left shifts run reversed through the right-moving chain.
    always_comb begin
        mode_e      = shift_mode_t'(mode);
        ctl_d.rev   = (mode_e == SHM_LSL);
        unique case (mode_e)
            SHM_ASR: ctl_d.fill = FILL_SIGN;
            SHM_ROR: ctl_d.fill = FILL_WRAP;
            default: ctl_d.fill = FILL_ZERO;
        endcase
        sign_d = din[WIDTH-1];
    end

    logic [AMT_W:0][WIDTH-1:0] chain_d;

    bshift_reverse #(.WIDTH(WIDTH)) u_rev_in (
        .en   (ctl_d.rev),
        .din  (din),
        .dout (chain_d[0])
    );

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        bshift_stage #(.WIDTH(WIDTH), .SHIFT(1 << k)) u_stage (
            .en   (amt[k]),
            .fill (ctl_d.fill),
            .sign (sign_d),
            .din  (chain_d[k]),
            .dout (chain_d[k+1])
        );
    end

    bshift_reverse #(.WIDTH(WIDTH)) u_rev_out (
        .en   (ctl_d.rev),
        .din  (chain_d[AMT_W]),
        .dout (dout)
    );

    // Port-level properties spanning decode, stages and reversal.
    logic [AMT_W:0]   amt_p1;
    logic [WIDTH-1:0] lo_mask;
    logic [WIDTH-1:0] hi_mask;
    logic [WIDTH-1:0] sgn_mask;

    always_comb begin
        amt_p1   = {1'b0, amt} + 1'b1;
        lo_mask  = ~({WIDTH{1'b1}} << amt);
        hi_mask  = ~({WIDTH{1'b1}} >> amt);
        sgn_mask = ~({WIDTH{1'b1}} >> amt_p1);

        a_r2_zero_passthru: assert ((amt != '0) || (dout == din))
            else $error("R2: zero amount altered data");
        a_r3_left_low_zero: assert ((mode_e != SHM_LSL) || ((dout & lo_mask) == '0))
            else $error("R3: low bits not zero after left shift");
        a_r4_right_high_zero: assert ((mode_e != SHM_LSR) || ((dout & hi_mask) == '0))
            else $error("R4: high bits not zero after logical right shift");
        a_r5_sign_fill: assert ((mode_e != SHM_ASR) ||
                                ((dout & sgn_mask) == (din[WIDTH-1] ? sgn_mask : '0)))
            else $error("R5: upper bits do not match sign");
        a_r6_rotate_ones: assert ((mode_e != SHM_ROR) || ($countones(dout) == $countones(din)))
            else $error("R6: rotate changed ones count");
    end

endmodule

// File: tb/bshift_core_tb.sv
`timescale 1ns/1ps
module bshift_core_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [3:0]   amt = '0;
    logic [1:0]   mode = '0;
    logic [W-1:0] dout;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    bshift_core #(.WIDTH(W)) u_dut (
        .din  (din),
        .amt  (amt),
        .mode (mode),
        .dout (dout)
    );

    function automatic logic [W-1:0] ref_val(input logic [W-1:0] d, input int a, input int m);
        logic [2*W-1:0] dbl;
        dbl = {d, d} >> a;
        case (m)
            0:       return d << a;
            1:       return d >> a;
            2:       return $signed(d) >>> a;
            default: return dbl[W-1:0];
        endcase
    endfunction

    function automatic string tag_of(input int a, input int m);
        string t;
        case (m)
            0:       t = "R3";
            1:       t = "R4";
            2:       t = "R5";
            default: t = "R6";
        endcase
        if (a == 0) t = {t, "/R2"};
        if (a == 1 || a == 2 || a == 4 || a == 8) t = {t, "/R7"};
        return {t, "/R1"};
    endfunction

    // Driver: apply on the falling edge and queue the expectation.
    task automatic drive(input logic [W-1:0] d, input int a, input int m);
        item_t it;
        @(negedge clk);
        din  = d;
        amt  = 4'(a);
        mode = 2'(m);
        it.exp = ref_val(d, a, m);
        it.tag = tag_of(a, m);
        sb_q.push_back(it);
    endtask

    // Monitor: compare on the rising edge, half a period after the change.
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (dout !== it.exp) begin
                n_fail++;
                $display("FAIL %s: din=%h amt=%0d mode=%0d got %h expected %h",
                         it.tag, din, amt, mode, dout, it.exp);
            end
        end
    end

    initial begin
        logic [W-1:0] pats [6];
        pats[0] = 16'h8001; pats[1] = 16'hA5C3; pats[2] = 16'h7FFF;
        pats[3] = 16'hFFFF; pats[4] = 16'h1234; pats[5] = 16'h0000;
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (dout !== '0) begin
            n_fail++;
            $display("FAIL R2: idle output got %h expected %h", dout, 16'h0000);
        end
        rst = 1'b0;
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 6; p++) begin
                for (int a = 0; a < W; a++) begin
                    drive(pats[p], a, m);
                end
            end
        end
        // R7: single-stage moves of a lone bit
        for (int k = 0; k < 4; k++) begin
            drive(16'h0001, 1 << k, 0);
            drive(16'h8000, 1 << k, 2);
            drive(16'h0001, 1 << k, 3);
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL R1: watchdog expired got %0d pending expected 0", sb_q.size());
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule